// File: doc/BRIEF.md
# Character Raster Timing Generator

The block produces the complete raster timing for a character-cell video display. It runs on the character clock and keeps four counters: character position in the line, scan line within the cell, character row, and the refresh address. From these it drives horizontal sync, vertical sync, a display-enable strobe, a 14-bit refresh memory address and a 4-bit row-within-cell address.

A host programs the geometry through a small two-location bus: one location holds an index, the other writes the register the index selects. A write is taken when the enable strobe falls. Line length, sync placement and frame height are held in staging registers and only reach the counters at the end of a frame, so a frame in progress never tears. Displayed width, displayed rows and cell height act at once. An active-low synchronous reset clears the counters and drives every output low, and it leaves the programmed geometry untouched.

Top module: `crt_timing_ctrl`

## Requirements
- R1: A register write is taken in the clock cycle where `bus_en` is sampled low after being high in the previous cycle. With `bus_sel` low, `bus_wdata[3:0]` becomes the index; with `bus_sel` high, `bus_wdata` is written to the register the index selects. Index map: 0 line total, 1 displayed width, 2 hsync start, 3 hsync width (4 bits), 4 row total (7 bits), 5 displayed rows (7 bits), 6 vsync row (7 bits), 7 vsync lines (4 bits), 8 cell height minus one (4 bits).
- R2: While `rst_n` is sampled low, every counter clears and, from the next clock on, all outputs are low.
- R3: The programmed registers keep their values through reset.
- R4: The character counter runs from 0 to the line total and wraps, so a line lasts line total + 1 clocks; each line advances the cell line, which wraps after the cell height value and then advances the character row, which wraps after the row total.
- R5: The refresh address starts each frame at 0, rises by one per clock while the character count is below the displayed width, then holds; each new character row starts at the previous row start plus the displayed width, and every line of a row starts again at that row start.
- R6: `hsync` is high for character counts c with start <= c < start + width.
- R7: `vsync` goes high at the first line of the vsync row and stays high for the programmed number of lines (none when that number is 0).
- R8: `disp_en` is high exactly when the character count is below the displayed width and the character row is below the displayed rows.
- R9: Writes to indices 0, 2, 3, 4, 6 and 7 take effect from the first clock of the next frame; writes to 1, 5 and 8 take effect on the next clock.
- R10: `row_addr` shows the current line within the character cell.
- R11: All outputs are registered and show the counter state of the previous clock, so the first clock after reset release shows count 0, row 0, address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_en | input | 1 | Write strobe, write taken on its falling edge |
| bus_sel | input | 1 | 0 selects the index location, 1 the data location |
| bus_wdata | input | 8 | Write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Display enable |
| mem_addr | output | 14 | Refresh memory address |
| row_addr | output | 4 | Line within the character cell |

## Verification
A wrong character count shows within one line as a sync period or displayed run of the wrong length; a wrong cell or row count shows within one character row through `row_addr`, `vsync` placement and the address jump at the row start. A staged value committed early or late changes the line period in the middle of a frame, visible within one line of the error. A lost register after reset shows on the first line after release.

// File: rtl/crt_pkg.sv
`timescale 1ns/1ps
// Shared widths, register indices and the power-up geometry of the raster
// timing generator. Assumes an 8-bit host bus.
package crt_pkg;
    parameter int DATA_W  = 8;   // host data width
    parameter int IDX_W   = 4;   // index register width
    parameter int HCNT_W  = 8;   // character counter width
    parameter int ROW_W   = 7;   // character row counter width
    parameter int CELL_W  = 4;   // line-within-cell width
    parameter int SYNC_W  = 4;   // sync width / line count width
    parameter int ADDR_W  = 14;  // refresh address width

    localparam logic [IDX_W-1:0] IX_HTOTAL = 4'd0;
    localparam logic [IDX_W-1:0] IX_HDISP  = 4'd1;
    localparam logic [IDX_W-1:0] IX_HSPOS  = 4'd2;
    localparam logic [IDX_W-1:0] IX_HSWID  = 4'd3;
    localparam logic [IDX_W-1:0] IX_VTOTAL = 4'd4;
    localparam logic [IDX_W-1:0] IX_VDISP  = 4'd5;
    localparam logic [IDX_W-1:0] IX_VSROW  = 4'd6;
    localparam logic [IDX_W-1:0] IX_VSLEN  = 4'd7;
    localparam logic [IDX_W-1:0] IX_CELLH  = 4'd8;

    typedef struct packed {
        logic [HCNT_W-1:0] htotal;
        logic [HCNT_W-1:0] hdisp;
        logic [HCNT_W-1:0] hs_pos;
        logic [SYNC_W-1:0] hs_wid;
        logic [ROW_W-1:0]  vtotal;
        logic [ROW_W-1:0]  vdisp;
        logic [ROW_W-1:0]  vs_row;
        logic [SYNC_W-1:0] vs_len;
        logic [CELL_W-1:0] cell_max;
    } crt_cfg_t;

    // About 95 clocks per line and 24 rows of 9 lines per frame.
    localparam crt_cfg_t CFG_POWERUP = '{
        htotal:   8'd94, hdisp: 8'd80, hs_pos: 8'd82, hs_wid: 4'd8,
        vtotal:   7'd23, vdisp: 7'd20, vs_row: 7'd21, vs_len: 4'd3,
        cell_max: 4'd8
    };
endpackage

// File: rtl/crt_regfile.sv
`timescale 1ns/1ps
// Host register file. Takes writes on the falling edge of the strobe as
// seen at the character clock, keeps line/frame geometry in staging
// registers until the frame boundary, applies the others at once.
// Assumes the strobe is slow against the character clock. Not reset:
// contents start from the power-up geometry and survive rst_n.
module crt_regfile
    import crt_pkg::*;
(
    input  logic              clk,
    input  logic              bus_en,
    input  logic              bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              commit,
    output crt_cfg_t          cfg
);
    logic              en_q    = 1'b0;
    logic [IDX_W-1:0]  index_q = '0;
    logic [HCNT_W-1:0] st_htotal = CFG_POWERUP.htotal;
    logic [HCNT_W-1:0] st_hs_pos = CFG_POWERUP.hs_pos;
    logic [SYNC_W-1:0] st_hs_wid = CFG_POWERUP.hs_wid;
    logic [ROW_W-1:0]  st_vtotal = CFG_POWERUP.vtotal;
    logic [ROW_W-1:0]  st_vs_row = CFG_POWERUP.vs_row;
    logic [SYNC_W-1:0] st_vs_len = CFG_POWERUP.vs_len;
    crt_cfg_t          cfg_q     = CFG_POWERUP;
    logic              wr_stb;
    logic              wr_data;

    assign wr_stb  = en_q & ~bus_en;
    assign wr_data = wr_stb & bus_sel;
    assign cfg     = cfg_q;

    // Delay the strobe one clock for falling-edge detection.
    always_ff @(posedge clk) begin
        en_q <= bus_en;
    end

    // Capture the index location.
    always_ff @(posedge clk) begin
        if (wr_stb && !bus_sel) index_q <= bus_wdata[IDX_W-1:0];
    end

    // Load the staging registers for frame-synchronous fields.
    always_ff @(posedge clk) begin
        if (wr_data) begin
            case (index_q)
                IX_HTOTAL: st_htotal <= bus_wdata[HCNT_W-1:0];
                IX_HSPOS:  st_hs_pos <= bus_wdata[HCNT_W-1:0];
                IX_HSWID:  st_hs_wid <= bus_wdata[SYNC_W-1:0];
                IX_VTOTAL: st_vtotal <= bus_wdata[ROW_W-1:0];
                IX_VSROW:  st_vs_row <= bus_wdata[ROW_W-1:0];
                IX_VSLEN:  st_vs_len <= bus_wdata[SYNC_W-1:0];
                default: ;
            endcase
        end
    end

    // Apply staged fields at the frame boundary, immediate fields on write.
    always_ff @(posedge clk) begin
        if (commit) begin
            cfg_q.htotal <= st_htotal;
            cfg_q.hs_pos <= st_hs_pos;
            cfg_q.hs_wid <= st_hs_wid;
            cfg_q.vtotal <= st_vtotal;
            cfg_q.vs_row <= st_vs_row;
            cfg_q.vs_len <= st_vs_len;
        end
        if (wr_data) begin
            case (index_q)
                IX_HDISP: cfg_q.hdisp    <= bus_wdata[HCNT_W-1:0];
                IX_VDISP: cfg_q.vdisp    <= bus_wdata[ROW_W-1:0];
                IX_CELLH: cfg_q.cell_max <= bus_wdata[CELL_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/crt_hcount.sv
`timescale 1ns/1ps
// Character counter for one scan line: counts 0..htotal, flags the line end,
// the displayed part and the horizontal sync window. Assumes htotal only
// changes at a line end.
module crt_hcount
    import crt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HCNT_W-1:0] htotal,
    input  logic [HCNT_W-1:0] hdisp,
    input  logic [HCNT_W-1:0] hs_pos,
    input  logic [SYNC_W-1:0] hs_wid,
    output logic [HCNT_W-1:0] hcnt,
    output logic              line_end,
    output logic              h_active,
    output logic              hs_raw
);
    localparam int EXT_W = HCNT_W + 1;
    logic [HCNT_W-1:0] hcnt_q;
    logic [EXT_W-1:0]  hs_end;

    assign hcnt     = hcnt_q;
    assign line_end = (hcnt_q >= htotal);
    assign h_active = (hcnt_q < hdisp);
    assign hs_end   = EXT_W'(hs_pos) + EXT_W'(hs_wid);
    assign hs_raw   = (hcnt_q >= hs_pos) && (EXT_W'(hcnt_q) < hs_end);

    // Advance the character position, wrapping after the line total.
    always_ff @(posedge clk) begin
        if (!rst_n)        hcnt_q <= '0;
        else if (line_end) hcnt_q <= '0;
        else               hcnt_q <= hcnt_q + 1'b1;
    end

    // R4: the count never passes the line total.
    a_r4_hcount_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt_q <= htotal);
endmodule

// File: rtl/crt_vcount.sv
`timescale 1ns/1ps
// Vertical timing: line within the cell, character row, frame end and a
// line counter for vertical sync. Steps once per line end.
module crt_vcount
    import crt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic [CELL_W-1:0] cell_max,
    input  logic [ROW_W-1:0]  vtotal,
    input  logic [ROW_W-1:0]  vdisp,
    input  logic [ROW_W-1:0]  vs_row,
    input  logic [SYNC_W-1:0] vs_len,
    output logic [CELL_W-1:0] cell_line,
    output logic              row_end,
    output logic              frame_end,
    output logic              v_active,
    output logic              vs_raw
);
    logic [CELL_W-1:0] cell_q;
    logic [ROW_W-1:0]  row_q;
    logic [ROW_W-1:0]  row_next;
    logic [SYNC_W-1:0] vs_left_q;
    logic              last_row;

    assign cell_line = cell_q;
    assign row_end   = (cell_q >= cell_max);
    assign last_row  = (row_q >= vtotal);
    assign frame_end = line_end && row_end && last_row;
    assign v_active  = (row_q < vdisp);
    assign vs_raw    = (vs_left_q != '0);

    // Row the next line belongs to.
    always_comb begin
        if (!row_end)      row_next = row_q;
        else if (last_row) row_next = '0;
        else               row_next = row_q + 1'b1;
    end

    // Step cell line and character row at every line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_q <= '0;
            row_q  <= '0;
        end else if (line_end) begin
            cell_q <= row_end ? '0 : cell_q + 1'b1;
            row_q  <= row_next;
        end
    end

    // Count down the remaining vertical sync lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_left_q <= '0;
        end else if (line_end) begin
            if (row_end && (row_next == vs_row)) vs_left_q <= vs_len;
            else if (vs_left_q != '0)           vs_left_q <= vs_left_q - 1'b1;
        end
    end

    // R7: vertical sync starts on the first line of a cell.
    a_r7_vsync_cell_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_raw) |-> (cell_q == '0));
endmodule

// File: rtl/crt_addrgen.sv
`timescale 1ns/1ps
// Refresh address: runs across the displayed part of a line, restarts at
// the row start on each line and moves the row start on by the displayed
// width at each new character row; returns to 0 at the frame end.
module crt_addrgen
    import crt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic              row_end,
    input  logic              frame_end,
    input  logic              h_active,
    input  logic [HCNT_W-1:0] hdisp,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] row_start_q;
    logic [ADDR_W-1:0] next_start;

    assign addr       = addr_q;
    assign next_start = row_start_q + ADDR_W'(hdisp);

    // Track the row start and the running refresh address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q      <= '0;
            row_start_q <= '0;
        end else if (line_end) begin
            if (frame_end) begin
                addr_q      <= '0;
                row_start_q <= '0;
            end else if (row_end) begin
                addr_q      <= next_start;
                row_start_q <= next_start;
            end else begin
                addr_q      <= row_start_q;
            end
        end else if (h_active) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    // R5: inside the displayed part the address steps by exactly one.
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (h_active && !line_end) |=> (addr_q == $past(addr_q) + 1'b1));
endmodule

// File: rtl/crt_timing_ctrl.sv
`timescale 1ns/1ps
// Top of the raster timing generator. Joins register file, horizontal and
// vertical counters and address generator, and registers every output so
// that reset can force them low. Assumes clk is the character clock.
module crt_timing_ctrl
    import crt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_sel,
    input  logic [7:0]        bus_wdata,
    output logic              hsync,
    output logic              vsync,
    output logic              disp_en,
    output logic [13:0]       mem_addr,
    output logic [3:0]        row_addr
);
    crt_cfg_t          cfg;
    logic [HCNT_W-1:0] hcnt;
    logic              line_end, h_active, hs_raw;
    logic [CELL_W-1:0] cell_line;
    logic              row_end, frame_end, v_active, vs_raw;
    logic              commit;
    logic [ADDR_W-1:0] addr;

    assign commit = frame_end & rst_n;

    crt_regfile u_regs (
        .clk(clk), .bus_en(bus_en), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .commit(commit), .cfg(cfg)
    );

    crt_hcount u_hcnt (
        .clk(clk), .rst_n(rst_n), .htotal(cfg.htotal), .hdisp(cfg.hdisp),
        .hs_pos(cfg.hs_pos), .hs_wid(cfg.hs_wid), .hcnt(hcnt),
        .line_end(line_end), .h_active(h_active), .hs_raw(hs_raw)
    );

    crt_vcount u_vcnt (
        .clk(clk), .rst_n(rst_n), .line_end(line_end),
        .cell_max(cfg.cell_max), .vtotal(cfg.vtotal), .vdisp(cfg.vdisp),
        .vs_row(cfg.vs_row), .vs_len(cfg.vs_len), .cell_line(cell_line),
        .row_end(row_end), .frame_end(frame_end), .v_active(v_active),
        .vs_raw(vs_raw)
    );

    crt_addrgen u_addr (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .row_end(row_end),
        .frame_end(frame_end), .h_active(h_active), .hdisp(cfg.hdisp),
        .addr(addr)
    );

    // Register the outputs; hold them low during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync    <= 1'b0;
            vsync    <= 1'b0;
            disp_en  <= 1'b0;
            mem_addr <= '0;
            row_addr <= '0;
        end else begin
            hsync    <= hs_raw;
            vsync    <= vs_raw;
            disp_en  <= h_active & v_active;
            mem_addr <= addr;
            row_addr <= cell_line;
        end
    end

    // R2: one clock of reset leaves every output low.
    a_r2_outputs_low: assert property (@(posedge clk)
        !rst_n |=> (!hsync && !vsync && !disp_en && mem_addr == '0 && row_addr == '0));

    // R6: sync only appears at or after the programmed start.
    a_r6_hsync_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> ($past(hcnt) >= $past(cfg.hs_pos)));

    // R9: line and frame totals move only at a frame boundary.
    a_r9_totals_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cfg.htotal) || !$stable(cfg.vtotal)) |-> $past(commit));
endmodule

// File: tb/crt_timing_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: a reference model fed by the driven inputs pushes the
// expected output set each clock; a monitor pops and compares at negedge.
module crt_timing_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0;
    logic       bus_sel = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       hsync, vsync, disp_en;
    logic [13:0] mem_addr;
    logic [3:0]  row_addr;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    crt_timing_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .hsync(hsync), .vsync(vsync),
        .disp_en(disp_en), .mem_addr(mem_addr), .row_addr(row_addr)
    );

    typedef struct {
        bit in_rst;
        bit first;
        bit hs, vs, de;
        int ma, ra;
    } exp_t;
    exp_t sb_q[$];

    // Reference model state (indices follow R1).
    int act [9] = '{94, 80, 82, 8, 23, 20, 21, 3, 8};
    int stg [9] = '{94, 80, 82, 8, 23, 20, 21, 3, 8};
    int h = 0, r = 0, c = 0, ma = 0, rs = 0, vsl = 0, idx = 0;
    bit en_q = 1'b0, was_rst = 1'b1;

    function automatic int fmask(int i);
        if (i <= 2) return 255;
        if (i == 3 || i >= 7) return 15;
        return 127;
    endfunction

    function automatic bit staged(int i);
        return (i == 0 || i == 2 || i == 3 || i == 4 || i == 6 || i == 7);
    endfunction

    // Model: expected outputs from pre-edge state, then step the state.
    always @(posedge clk) begin
        exp_t e;
        bit le, re, fe, wr;
        int nc;
        e.in_rst = !rst_n;
        e.first  = rst_n && was_rst;
        if (!rst_n) begin
            e.hs = 0; e.vs = 0; e.de = 0; e.ma = 0; e.ra = 0;
            h = 0; r = 0; c = 0; ma = 0; rs = 0; vsl = 0;
            fe = 0;
        end else begin
            e.hs = (h >= act[2]) && (h < act[2] + act[3]);
            e.vs = (vsl != 0);
            e.de = (h < act[1]) && (c < act[5]);
            e.ma = ma;
            e.ra = r;
            le = (h >= act[0]);
            re = (r >= act[8]);
            fe = le && re && (c >= act[4]);
            if (le) begin
                nc = re ? ((c >= act[4]) ? 0 : c + 1) : c;
                if (re && nc == act[6]) vsl = act[7];
                else if (vsl != 0) vsl = vsl - 1;
                if (fe) begin rs = 0; ma = 0; end
                else if (re) begin rs = (rs + act[1]) % 16384; ma = rs; end
                else ma = rs;
                h = 0;
                r = re ? 0 : r + 1;
                c = nc;
            end else begin
                if (h < act[1]) ma = (ma + 1) % 16384;
                h = h + 1;
            end
        end
        sb_q.push_back(e);
        // R9: staged values reach the counters at the frame boundary.
        if (fe) begin
            for (int i = 0; i < 9; i++) if (staged(i)) act[i] = stg[i];
        end
        // R1: write on the falling strobe.
        wr = en_q && !bus_en;
        if (wr && !bus_sel) idx = bus_wdata[3:0];
        else if (wr && bus_sel && idx < 9) begin
            if (staged(idx)) stg[idx] = bus_wdata & fmask(idx);
            else act[idx] = bus_wdata & fmask(idx);
        end
        en_q = bus_en;
        was_rst = !rst_n;
    end

    task automatic check(bit ok, string req, int actual, int expected);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
        end
    endtask

    // Monitor: pop the expected set and compare, away from the clock edge.
    int cyc = 0, last_rise = 0, period = 0, rise_cnt = 0;
    bit hs_prev = 1'b0;
    always @(negedge clk) begin
        exp_t e;
        string t;
        cyc++;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            if (e.in_rst) begin
                check(!hsync && !vsync && !disp_en && mem_addr == 0 && row_addr == 0,
                      "R2 outputs low in reset", {hsync, vsync, disp_en}, 0);
            end else begin
                t = e.first ? " R11" : "";
                check(hsync == e.hs, {"R6 hsync", t}, hsync, e.hs);
                check(vsync == e.vs, {"R7 vsync", t}, vsync, e.vs);
                check(disp_en == e.de, {"R8 disp_en", t}, disp_en, e.de);
                check(int'(mem_addr) == e.ma, {"R5 mem_addr", t}, mem_addr, e.ma);
                check(int'(row_addr) == e.ra, {"R10 row_addr", t}, row_addr, e.ra);
            end
        end
        if (hsync && !hs_prev) begin
            period = cyc - last_rise;
            last_rise = cyc;
            rise_cnt++;
        end
        hs_prev = hsync;
    end

    task automatic wait_rises(int n);
        int target;
        target = rise_cnt + n;
        while (rise_cnt < target) begin @(negedge clk); #1; end
    endtask

    task automatic wr_reg(int index, int value);
        @(negedge clk); bus_sel = 0; bus_wdata = 8'(index); bus_en = 1;
        @(negedge clk); bus_en = 0;
        @(negedge clk); bus_sel = 1; bus_wdata = 8'(value); bus_en = 1;
        @(negedge clk); bus_en = 0;
        @(negedge clk);
    endtask

    task automatic count_de(output int n);
        wait_rises(1);
        while (!disp_en) begin @(negedge clk); #1; end
        n = 0;
        while (disp_en) begin n++; @(negedge clk); #1; end
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (300) @(negedge clk);
        // R1: program a small geometry through index/data writes.
        wr_reg(0, 9); wr_reg(1, 6); wr_reg(2, 7); wr_reg(3, 2);
        wr_reg(4, 4); wr_reg(5, 3); wr_reg(6, 3); wr_reg(7, 2); wr_reg(8, 2);
        // R9: line total still the old one within this frame.
        wait_rises(3);
        check(period == 95, "R9 staged total held until frame end", period, 95);
        repeat (22000) @(negedge clk);
        wait_rises(3);
        check(period == 10, "R4 line period", period, 10);
        count_de(n);
        check(n == 6, "R8 displayed run length", n, 6);
        // R3: reset mid-frame keeps the programmed geometry.
        repeat (37) @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        wait_rises(3);
        check(period == 10, "R3 geometry kept through reset", period, 10);
        // R1: immediate displayed width.
        wr_reg(1, 4);
        count_de(n);
        check(n == 4, "R1 immediate displayed width", n, 4);
        // R9: staged line total near frame start.
        while (!vsync) begin @(negedge clk); #1; end
        while (vsync) begin @(negedge clk); #1; end
        wait_rises(5);
        wr_reg(0, 11);
        wait_rises(2);
        check(period == 10, "R9 new total waits for frame end", period, 10);
        repeat (400) @(negedge clk);
        wait_rises(3);
        check(period == 12, "R9 new total after frame end", period, 12);
        repeat (200) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule